// File: doc/BRIEF.md
# Receive Control-Character Matcher

This block sits between a serial receiver and its receive-buffer logic. Each character the receiver delivers is compared against a small table that the host can program. Each table entry holds a character value, an end marker and a divert flag. The comparison runs from entry 0 upward. The first live entry whose value equals the character decides what happens to it. An entry with its end marker set is not live, and it stops the comparison: no entry beyond it is looked at. This lets the host use only part of the table, or keep the last slot for another purpose.

There are three outcomes for a character. A match on an entry whose divert flag is clear keeps the character in the data stream, pulses a buffer-close strobe alongside it and raises the receive event. A match on an entry whose divert flag is set removes the character from the stream. The character is captured in a control-character register and the control event is raised, and the current buffer stays open. A character that matches nothing is forwarded unchanged, with no close and no event. Both event flags stay set until the host clears them with a write-one-to-clear strobe.

The decision is held in a four-state machine that is updated on the clock edge that samples the input strobe. The states are ST_IDLE (no character this cycle), ST_PASS (forwarded, unmatched), ST_CLOSE (forwarded, buffer closed) and ST_DIVERT (captured, not forwarded). On each edge the machine moves from any state to one of these. It goes to ST_IDLE when the strobe is low, to ST_PASS when no live entry matches, to ST_CLOSE on a keep-match and to ST_DIVERT on a divert-match. The outputs are decoded from the current state, so every result appears exactly one clock after its strobe.

Top module: `rx_ctrl_matcher`

## Requirements
- R1: After reset every table entry has its end marker set and no match is possible. out_valid, buf_close, evt_rx, evt_cc and ctl_char are all zero.
- R2: A table write (tbl_we high at a clock edge) stores tbl_value, tbl_end and tbl_reject into entry tbl_idx. The new entry applies to any character strobed on a later edge.
- R3: Entries are examined from index 0 upward. An entry with tbl_end=1 is never matched, and all entries with a higher index are ignored.
- R4: When several live entries hold the same value, the lowest-indexed one decides the outcome.
- R5: A match on an entry with tbl_reject=0 gives, one clock after the strobe, out_valid=1, out_char equal to the received character and buf_close=1, all in the same cycle.
- R6: A match on an entry with tbl_reject=1 gives, one clock after the strobe, out_valid=0 and buf_close=0, and ctl_char becomes the received character. ctl_char keeps its value until the next divert-match.
- R7: A character that matches no live entry gives, one clock after the strobe, out_valid=1 with out_char unchanged, buf_close=0, and no change to either event flag.
- R8: evt_rx is set on each keep-match, and evt_cc is set on each divert-match. Both flags are set in the same cycle as the corresponding output.
- R9: The event flags are sticky. evt_clr bit 0 clears evt_rx, and evt_clr bit 1 clears evt_cc. If a clear and a set hit the same flag on the same edge, the set wins.
- R10: With all eight entries live (every end marker zero), every entry, including entry 7, can match. With entry 7's end marker set, entry 7 is never matched.
- R11: A cycle without rx_valid gives out_valid=0 and buf_close=0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 3 | Entry index to write |
| tbl_value | input | 8 | Character value for the entry |
| tbl_end | input | 1 | End marker: 1 = entry not live, stops the scan |
| tbl_reject | input | 1 | Divert flag: 1 = capture instead of forwarding |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | 8 | Received character |
| evt_clr | input | 2 | Write-one-to-clear: bit 0 receive event, bit 1 control event |
| out_valid | output | 1 | Character forwarded to buffer logic |
| out_char | output | 8 | Forwarded character |
| buf_close | output | 1 | Close the current buffer after this character |
| ctl_char | output | 8 | Last diverted control character |
| evt_rx | output | 1 | Sticky receive event flag |
| evt_cc | output | 1 | Sticky control-character event flag |

## Verification
A wrong state in this block shows at the ports one clock after the strobe that caused it. An end marker stored badly or a broken scan chain changes which characters close a buffer or are diverted. This appears as a wrong out_valid or buf_close on exactly the characters held in the table, so every character value is swept against several table layouts. A stale capture register or a leaky event flag shows up as a wrong ctl_char or evt value on the very next character. The flags are checked and cleared after every character.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PASS   = 2'd1,
        ST_CLOSE  = 2'd2,
        ST_DIVERT = 2'd3
    } rcm_state_e;

    typedef struct packed {
        logic hit;
        logic divert;
    } rcm_verdict_t;

endpackage

// File: rtl/rcm_table.sv
module rcm_table #(
    parameter int ENTRIES = 8,
    parameter int CW      = 8,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IW-1:0]                  wr_idx,
    input  logic [CW-1:0]                  wr_value,
    input  logic                           wr_end,
    input  logic                           wr_reject,
    output logic [ENTRIES-1:0][CW-1:0]     ent_value,
    output logic [ENTRIES-1:0]             ent_end,
    output logic [ENTRIES-1:0]             ent_reject
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_value[g]  <= '0;
                ent_end[g]    <= 1'b1;
                ent_reject[g] <= 1'b0;
            end else if (sel) begin
                ent_value[g]  <= wr_value;
                ent_end[g]    <= wr_end;
                ent_reject[g] <= wr_reject;
            end
        end
    end

endmodule

// File: rtl/rcm_scan.sv
module rcm_scan
    import rcm_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CW      = 8
) (
    input  logic [ENTRIES-1:0][CW-1:0] ent_value,
    input  logic [ENTRIES-1:0]         ent_end,
    input  logic [ENTRIES-1:0]         ent_reject,
    input  logic [CW-1:0]              probe,
    output rcm_verdict_t               verdict
);

    logic [ENTRIES-1:0] live;
    logic [ENTRIES-1:0] hit_vec;

    assign live[0] = 1'b1;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic eq;
        assign eq         = (ent_value[g] == probe);
        assign hit_vec[g] = live[g] & ~ent_end[g] & eq;
        if (g < ENTRIES - 1) begin : g_chain
            assign live[g+1] = live[g] & ~ent_end[g] & ~eq;
        end
    end

    always_comb begin
        verdict.hit    = |hit_vec;
        verdict.divert = |(hit_vec & ent_reject);
    end

endmodule

// File: rtl/rcm_events.sv
module rcm_events (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_rx,
    input  logic       set_cc,
    input  logic [1:0] clr,
    output logic       evt_rx,
    output logic       evt_cc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_rx <= 1'b0;
            evt_cc <= 1'b0;
        end else begin
            evt_rx <= set_rx | (evt_rx & ~clr[0]);
            evt_cc <= set_cc | (evt_cc & ~clr[1]);
        end
    end

    assert_rx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_rx) && !$past(clr[0])) |-> evt_rx);

    assert_cc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_cc) && !$past(clr[1])) |-> evt_cc);

endmodule

// File: rtl/rx_ctrl_matcher.sv
module rx_ctrl_matcher
    import rcm_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CW      = 8,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tbl_we,
    input  logic [IW-1:0] tbl_idx,
    input  logic [CW-1:0] tbl_value,
    input  logic          tbl_end,
    input  logic          tbl_reject,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_char,
    input  logic [1:0]    evt_clr,
    output logic          out_valid,
    output logic [CW-1:0] out_char,
    output logic          buf_close,
    output logic [CW-1:0] ctl_char,
    output logic          evt_rx,
    output logic          evt_cc
);

    logic [ENTRIES-1:0][CW-1:0] ent_value;
    logic [ENTRIES-1:0]         ent_end;
    logic [ENTRIES-1:0]         ent_reject;
    rcm_verdict_t               verdict;

    rcm_state_e    state_q, state_d;
    logic [CW-1:0] char_q;
    logic [CW-1:0] ctl_q;

    rcm_table #(.ENTRIES(ENTRIES), .CW(CW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_we),
        .wr_idx     (tbl_idx),
        .wr_value   (tbl_value),
        .wr_end     (tbl_end),
        .wr_reject  (tbl_reject),
        .ent_value  (ent_value),
        .ent_end    (ent_end),
        .ent_reject (ent_reject)
    );

    rcm_scan #(.ENTRIES(ENTRIES), .CW(CW)) u_scan (
        .ent_value  (ent_value),
        .ent_end    (ent_end),
        .ent_reject (ent_reject),
        .probe      (rx_char),
        .verdict    (verdict)
    );

    // next-state decision: any state may move to any state
    always_comb begin
        if (!rx_valid)           state_d = ST_IDLE;
        else if (!verdict.hit)   state_d = ST_PASS;
        else if (verdict.divert) state_d = ST_DIVERT;
        else                     state_d = ST_CLOSE;
    end

    // state register with character holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            char_q  <= '0;
            ctl_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rx_valid)              char_q <= rx_char;
            if (state_d == ST_DIVERT)  ctl_q  <= rx_char;
        end
    end

    // output decode
    always_comb begin
        out_valid = 1'b0;
        buf_close = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PASS:   out_valid = 1'b1;
            ST_CLOSE: begin
                out_valid = 1'b1;
                buf_close = 1'b1;
            end
            ST_DIVERT: ;
            default:   ;
        endcase
    end

    assign out_char = char_q;
    assign ctl_char = ctl_q;

    rcm_events u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_rx (state_d == ST_CLOSE),
        .set_cc (state_d == ST_DIVERT),
        .clr    (evt_clr),
        .evt_rx (evt_rx),
        .evt_cc (evt_cc)
    );

    assert_close_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |-> out_valid);

    assert_close_raises_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |-> evt_rx);

    assert_fwd_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid) |-> (out_char == $past(rx_char)));

    assert_gap_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> (!out_valid && !buf_close));

    assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DIVERT) |-> $stable(ctl_char));

endmodule

// File: tb/sim_rx_ctrl_matcher.sv
module sim_rx_ctrl_matcher;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbl_we = 1'b0;
    logic [2:0] tbl_idx = '0;
    logic [7:0] tbl_value = '0;
    logic       tbl_end = 1'b0;
    logic       tbl_reject = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic [1:0] evt_clr = '0;
    logic       out_valid, buf_close, evt_rx, evt_cc;
    logic [7:0] out_char, ctl_char;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_val [8];
    bit         m_end [8];
    bit         m_rej [8];
    logic [7:0] m_ctl;

    always #10 clk = ~clk;

    rx_ctrl_matcher u0 (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_value(tbl_value), .tbl_end(tbl_end), .tbl_reject(tbl_reject),
        .rx_valid(rx_valid), .rx_char(rx_char), .evt_clr(evt_clr),
        .out_valid(out_valid), .out_char(out_char), .buf_close(buf_close),
        .ctl_char(ctl_char), .evt_rx(evt_rx), .evt_cc(evt_cc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int i, input logic [7:0] v, input bit e, input bit r);
        @(negedge clk);
        tbl_we = 1; tbl_idx = 3'(i); tbl_value = v; tbl_end = e; tbl_reject = r;
        @(negedge clk);
        tbl_we = 0;
        m_val[i] = v; m_end[i] = e; m_rej[i] = r;
    endtask

    function automatic int lookup(input logic [7:0] c);
        for (int i = 0; i < 8; i++) begin
            if (m_end[i]) return -1;
            if (m_val[i] == c) return i;
        end
        return -1;
    endfunction

    // strobe one character (with optional clear in the same cycle), sample after
    task automatic send(input logic [7:0] c, input logic [1:0] clr);
        @(negedge clk);
        rx_valid = 1; rx_char = c; evt_clr = clr;
        @(negedge clk);
        rx_valid = 0; evt_clr = 0;
    endtask

    task automatic sweep(input string tag);
        for (int c = 0; c < 256; c++) begin
            int k;
            bit ex_v, ex_cl, ex_rx, ex_cc;
            k = lookup(8'(c));
            ex_v  = (k < 0) || !m_rej[k];
            ex_cl = (k >= 0) && !m_rej[k];
            ex_rx = ex_cl;
            ex_cc = (k >= 0) && m_rej[k];
            if (ex_cc) m_ctl = 8'(c);
            send(8'(c), 2'b00);
            chk(out_valid == ex_v, ex_cc ? "R6" : "R7", {tag, " out_valid"}, out_valid, ex_v);
            if (ex_v) chk(out_char == 8'(c), "R7", {tag, " out_char"}, out_char, c);
            chk(buf_close == ex_cl, (k >= 0) ? "R5" : "R7", {tag, " buf_close"}, buf_close, ex_cl);
            chk(ctl_char == m_ctl, "R6", {tag, " ctl_char"}, ctl_char, m_ctl);
            chk(evt_rx == ex_rx, "R8", {tag, " evt_rx"}, evt_rx, ex_rx);
            chk(evt_cc == ex_cc, "R8", {tag, " evt_cc"}, evt_cc, ex_cc);
            @(negedge clk);
            evt_clr = 2'b11;
            @(negedge clk);
            evt_clr = 2'b00;
            chk(!evt_rx && !evt_cc, "R9", {tag, " clear"}, {evt_rx, evt_cc}, 0);
            chk(!out_valid && !buf_close, "R11", {tag, " idle"}, {out_valid, buf_close}, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_val[i] = 0; m_end[i] = 1; m_rej[i] = 0;
        end
        m_ctl = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!out_valid && !buf_close, "R1", "outputs", {out_valid, buf_close}, 0);
        chk(!evt_rx && !evt_cc, "R1", "events", {evt_rx, evt_cc}, 0);
        chk(ctl_char == 0, "R1", "ctl_char", ctl_char, 0);
        rst_n = 1;
        @(negedge clk);
        sweep("R1 empty table");

        // R2 R3: partial table, end marker at 4 hides 5..7
        put(0, 8'h13, 0, 0);
        put(1, 8'h11, 0, 1);
        put(2, 8'h0D, 0, 0);
        put(3, 8'h7E, 0, 1);
        put(4, 8'h40, 1, 0);
        put(5, 8'h41, 0, 0);
        put(6, 8'h42, 0, 1);
        put(7, 8'h43, 0, 0);
        sweep("R2 R3 partial");

        // R4: duplicates, lowest index wins
        put(0, 8'h55, 0, 1);
        put(1, 8'h55, 0, 0);
        put(2, 8'hAA, 0, 0);
        put(3, 8'hAA, 0, 1);
        sweep("R4 duplicates");

        // R10: all eight live
        for (int i = 0; i < 8; i++) put(i, 8'(8'hF0 + i), 0, (i % 2) == 1);
        sweep("R10 full");
        put(7, 8'hF7, 1, 0);
        sweep("R10 entry7 reserved");

        // R9: set wins over same-edge clear
        put(0, 8'h21, 0, 0);
        put(1, 8'h22, 0, 1);
        send(8'h21, 2'b11);
        chk(evt_rx == 1, "R9", "set beats clear rx", evt_rx, 1);
        send(8'h22, 2'b11);
        chk(evt_cc == 1, "R9", "set beats clear cc", evt_cc, 1);
        chk(evt_rx == 0, "R9", "rx cleared", evt_rx, 0);
        send(8'h21, 2'b10);
        chk(evt_rx && !evt_cc, "R9", "selective clear", {evt_rx, evt_cc}, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule